// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is the master side of a link to a three-wire serial EEPROM organised as 512 locations of 8 bits. A host places one request at a time: a read, a write or a write-enable, with a 9-bit address and, for writes, a data byte. The controller frames the request as whole bytes, drives chip select, serial clock and serial data, and returns the read byte with a one-cycle done pulse.

Each command is padded with leading zeros up to a byte boundary, so the address LSB is the last bit of the second byte. The memory ignores those zeros until it sees the start bit, which lets chip select rise before the first byte. Outgoing bits change on the falling serial clock edge. Incoming bits are sampled on the falling edge, because the memory updates its output on the rising edge. After a write, the controller briefly deselects the memory and then polls its ready line until the programming cycle ends.

Top module: `ee3w_ctrl`

## Requirements
- R1: After reset, chip select, serial clock, busy and done are all 0.
- R2: The serial clock sits low while idle. Each command is 16 bits sent MSB first: four zeros, a 1 start bit, a 2-bit opcode, then address bits 8 down to 0. The opcodes are read = 10, write = 01 and write-enable = 00. For write-enable, the address field is 11 followed by seven zeros.
- R3: The data-out line changes only together with a falling serial clock edge or at request acceptance, so it is stable at every rising edge.
- R4: A read adds 8 clock pulses after the command. Data-in is sampled at the falling edge of each pulse, MSB first. The byte is presented on the read-data port when done pulses.
- R5: A write sends its 8 data bits MSB first directly after the command, for 24 bits in all.
- R6: After the last write bit, chip select stays low for at least 2*CLK_DIV system cycles and then rises. Data-in is then polled with chip select high. Done is withheld while data-in is 0. Once data-in reads 1, chip select drops and done pulses.
- R7: Busy is 1 from the cycle after a request is accepted until done. A request raised while busy is ignored and starts nothing.
- R8: The serial clock period is 2*CLK_DIV system cycles, and the serial clock is never high while chip select is low.
- R9: Done is a single-cycle pulse, and busy is 0 in the cycle done is 1.
- R10: The op input encoding is 0 = read, 1 = write, 2 or 3 = write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, taken only while busy is 0 |
| op_i | input | 2 | Operation: 0 read, 1 write, 2/3 write-enable |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| cs_o | output | 1 | Memory chip select, active high |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the memory |
| sdi_i | input | 1 | Serial data from the memory, also its ready line |

## Verification
Every serial event is tied to the divider. A rising serial edge comes CLK_DIV system cycles after acceptance, and each half period is CLK_DIV cycles. A read therefore finishes 48*CLK_DIV cycles after acceptance. The end of a write's shifting comes 48*CLK_DIV cycles after acceptance, and done follows within CLK_DIV+1 cycles of the ready line going high. The bench does not hard-code these completion times. It waits for the named edges of chip select, serial clock or done, samples on the falling system clock edge, and bounds each wait with a timeout. The exact serial period and the one-cycle busy and done timings are measured by counting cycles between edges.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_GAP, ST_POLL
  } ee3w_state_e;

  // host op code to device opcode bits
  function automatic logic [1:0] dev_opcode(input logic [1:0] hop);
    case (hop)
      2'd0:    dev_opcode = 2'b10;
      2'd1:    dev_opcode = 2'b01;
      default: dev_opcode = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ee3w_shreg.sv
module ee3w_shreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/ee3w_ctrl.sv
module ee3w_ctrl #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  import ee3w_pkg::*;

  localparam int RAW_W = ADDR_W + 3;
  localparam int PAD_W = (8 - (RAW_W % 8)) % 8;
  localparam int CMD_W = RAW_W + PAD_W;
  localparam int SH_W  = CMD_W + DATA_W;
  localparam int BW    = $clog2(SH_W + 1);

  ee3w_state_e state;
  logic [1:0]     op_q;
  logic [BW-1:0]  bits;
  logic           gap_cnt;
  logic           tick;
  logic [SH_W-1:0] q;
  logic [SH_W-1:0] frame;
  logic [ADDR_W-1:0] addr_eff;
  logic           accept, shift, finish;
  logic [BW-1:0]  send_last;

  assign accept = (state == ST_IDLE) && req_i;
  assign shift  = tick && sclk_o && (state == ST_SEND || state == ST_RECV);

  always_comb begin
    addr_eff = addr_i;
    if (op_i[1]) addr_eff = {2'b11, {(ADDR_W-2){1'b0}}};
    frame = {{PAD_W{1'b0}}, 1'b1, dev_opcode(op_i), addr_eff,
             (op_i == 2'd1) ? wdata_i : {DATA_W{1'b0}}};
    send_last = (op_q == 2'd1) ? BW'(SH_W - 1) : BW'(CMD_W - 1);
    finish = 1'b0;
    case (state)
      ST_SEND: finish = tick && sclk_o && bits == send_last && op_q[1];
      ST_RECV: finish = tick && sclk_o && bits == BW'(DATA_W - 1);
      ST_POLL: finish = tick && sdi_i;
      default: finish = 1'b0;
    endcase
  end

  ee3w_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(state != ST_IDLE), .tick(tick)
  );

  ee3w_shreg #(.W(SH_W)) u_sh (
    .clk(clk), .rst(rst), .load(accept), .load_val(frame),
    .shift(shift), .sin(sdi_i), .q(q)
  );

  assign sdo_o = (state == ST_SEND) ? q[SH_W-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      bits    <= '0;
      gap_cnt <= 1'b0;
      cs_o    <= 1'b0;
      sclk_o  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (finish) begin
        state  <= ST_IDLE;
        cs_o   <= 1'b0;
        sclk_o <= 1'b0;
        busy_o <= 1'b0;
        done_o <= 1'b1;
        bits   <= '0;
        if (state == ST_RECV) rdata_o <= {q[DATA_W-2:0], sdi_i};
      end else begin
        case (state)
          ST_IDLE: if (accept) begin
            op_q   <= op_i;
            cs_o   <= 1'b1;
            busy_o <= 1'b1;
            bits   <= '0;
            state  <= ST_SEND;
          end
          ST_SEND, ST_RECV: if (tick) begin
            sclk_o <= ~sclk_o;
            if (sclk_o) begin
              bits <= bits + 1'b1;
              if (state == ST_SEND && bits == send_last) begin
                bits <= '0;
                if (op_q == 2'd0) state <= ST_RECV;
                else begin
                  state   <= ST_GAP;
                  cs_o    <= 1'b0;
                  gap_cnt <= 1'b0;
                end
              end
            end
          end
          ST_GAP: if (tick) begin
            gap_cnt <= 1'b1;
            if (gap_cnt) begin
              cs_o  <= 1'b1;
              state <= ST_POLL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_o |-> !sclk_o);
  // R3
  sdo_stable_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(sdo_o));
  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !cs_o);
  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && req_i) |=> busy_o);
  // R6
  poll_waits_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && !sdi_i) |=> !done_o);
endmodule

// File: tb/sim_ee3w_ctrl.sv
module sim_ee3w_ctrl;
  localparam int DIV = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] op = '0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic done, busy, cs, sclk, sdo;
  logic sdi;
  logic rd_mode = 1'b0, rd_drive = 1'b0, poll_sdi = 1'b0;
  logic [7:0] rd_val = '0;
  logic [31:0] log_bits = '0;
  int nbit = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign sdi = rd_mode ? rd_drive : poll_sdi;

  ee3w_ctrl #(.ADDR_W(9), .DATA_W(8), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .cs_o(cs), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi)
  );

  // memory model: log bits on rising clock, drive read data on rising clock
  always @(posedge sclk or posedge cs) begin
    if (!sclk) begin
      nbit = 0;
      log_bits = '0;
    end else begin
      log_bits = {log_bits[30:0], sdo};
      nbit++;
      if (nbit >= 17 && nbit <= 24) rd_drive = rd_val[24 - nbit];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(input logic [1:0] o, input logic [8:0] a);
    logic [1:0] opc;
    logic [8:0] ae;
    opc = (o == 2'd0) ? 2'b10 : (o == 2'd1) ? 2'b01 : 2'b00;
    ae  = o[1] ? 9'h180 : a;
    return {4'b0000, 1'b1, opc, ae};
  endfunction

  task automatic issue(input logic [1:0] o, input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    op = o; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R7 busy after accept", busy, 1);
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    chk(cs === 0 && sclk === 0 && busy === 0 && done === 0, "R1 reset outputs",
        {cs, sclk, busy, done}, 0);
  endtask

  task automatic t_read(input logic [8:0] a, input logic [7:0] d, input bit poke);
    bit ok;
    rd_mode = 1'b1; rd_val = d;
    issue(2'd0, a, 8'h00);
    if (poke) begin
      repeat (20) @(negedge clk);
      op = 2'd1; addr = ~a; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R4 read completes", ok, 1);
    chk(rdata === d, "R4 read data", rdata, d);
    chk(nbit == 24, "R4 read pulse count", nbit, 24);
    chk(log_bits[23:8] === exp_cmd(2'd0, a), "R2 read command frame", log_bits[23:8], exp_cmd(2'd0, a));
    chk(log_bits[23:20] === 4'b0, "R2 leading zeros", log_bits[23:20], 0);
    chk(busy === 0 && cs === 0, "R9 busy low with done", {busy, cs}, 0);
    @(negedge clk);
    chk(done === 0, "R9 done one cycle", done, 0);
    if (poke) begin
      bit started = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (cs || busy) started = 1'b1;
      end
      chk(!started, "R7 request while busy ignored", started, 0);
    end
    rd_mode = 1'b0;
  endtask

  task automatic t_write(input logic [8:0] a, input logic [7:0] d, input int hold);
    int low = 0, bad = 0;
    bit ok;
    logic [23:0] exp;
    poll_sdi = 1'b0;
    issue(2'd1, a, d);
    for (int i = 0; i < 2000 && cs; i++) @(negedge clk);
    exp = {exp_cmd(2'd1, a), d};
    chk(nbit == 24, "R5 write bit count", nbit, 24);
    chk(log_bits[23:0] === exp, "R5 write frame and data", log_bits[23:0], exp);
    chk(done === 0 && busy === 1, "R6 no done before poll", {done, busy}, 2'b01);
    for (int i = 0; i < 2000 && !cs; i++) begin @(negedge clk); low++; end
    chk(low >= 2 * DIV, "R6 deselect gap length", low, 2 * DIV);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (done || !cs) bad++;
    end
    chk(bad == 0, "R6 held while not ready", bad, 0);
    poll_sdi = 1'b1;
    ok = 1'b0;
    for (int i = 0; i < DIV + 2; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    chk(ok, "R6 done after ready", ok, 1);
    chk(cs === 0, "R6 deselect after ready", cs, 0);
    poll_sdi = 1'b0;
  endtask

  task automatic t_wren(input logic [1:0] o);
    bit ok;
    issue(o, 9'h055, 8'hFF);
    wait_done(ok);
    chk(ok, "R10 write-enable completes", ok, 1);
    chk(nbit == 16, "R10 write-enable length", nbit, 16);
    chk(log_bits[15:0] === 16'h0980, "R2 write-enable frame", log_bits[15:0], 16'h0980);
  endtask

  task automatic t_period();
    int t = 0;
    bit ok;
    rd_mode = 1'b1; rd_val = 8'h3C;
    issue(2'd0, 9'h001, 8'h00);
    chk(sclk === 0, "R2 clock low at start", sclk, 0);
    @(posedge sclk);
    @(negedge clk);
    while (sclk) begin @(negedge clk); t++; end
    while (!sclk) begin @(negedge clk); t++; end
    chk(t == 2 * DIV, "R8 serial clock period", t, 2 * DIV);
    wait_done(ok);
    chk(rdata === 8'h3C, "R4 read data second pattern", rdata, 8'h3C);
    rd_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(9'h1A5, 8'hA5, 1'b0);
    t_read(9'h000, 8'h81, 1'b0);
    t_write(9'h1FF, 8'h5A, 37);
    t_write(9'h022, 8'hC3, 0);
    t_wren(2'd2);
    t_wren(2'd3);
    t_read(9'h0F0, 8'h7E, 1'b1);
    t_period();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule